// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block is the external interrupt front end of a small microcontroller. It watches a set of input pins, two by default. Each pin first passes through a synchroniser. A two-bit sense field then picks one of four detection modes for that pin: low level, any change, falling edge or rising edge. In the three edge modes, a detected event latches a pending flag. Software can read that flag, and clears it by writing a one to its bit. The CPU also clears it by pulsing an acknowledge line when the service routine starts.

Low level mode works differently. The pending flag is never set and always reads zero. The request follows the synchronised pin level instead. While the pin stays low, the request comes back after every acknowledge, so the interrupt keeps firing until the pin returns high.

A channel raises its request line only when three things are all true: its pending condition, its own enable bit, and the global interrupt enable input. A small register port, with combinational read and synchronous write, gives access to the sense fields, the enable mask and the pending flags. Vector fetch and return sequencing belong to the CPU and are not part of this block.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, every register reads zero: sense fields (address 0), enables (address 1) and pending flags (address 2). All request outputs are low. A sense value of 00 means low level mode.
- R2: With sense code 10 (falling edge), a high-to-low change on the pin sets the channel's pending flag, read at address 2 with channel i at bit i. The flag reads one after the third rising clock edge following the change, and still reads zero after the second.
- R3: With sense code 11 (rising edge), a low-to-high change sets the pending flag. A high-to-low change does not set it.
- R4: With sense code 01 (any change), both a rising and a falling pin change set the pending flag.
- R5: Writing address 2 with a one in bit i clears channel i's pending flag. A zero in bit i leaves the flag unchanged.
- R6: In an edge mode, a one-cycle pulse on ack_i[i] clears channel i's pending flag at the following clock edge.
- R7: irq_req_o[i] is high only when channel i's pending condition, its enable bit (address 1, bit i) and gie_i are all high. If any one of them is low, the request is low.
- R8: In low level mode, the pending flag always reads zero, even with the pin low and whether or not the channel is enabled.
- R9: In low level mode, the pending condition is the inverted synchronised pin. The request stays high through an acknowledge while the pin remains low. It drops two clock edges after the pin goes high.
- R10: If a selected edge is detected in the same cycle that software writes one to clear the flag, the flag ends that cycle set.
- R11: Changing a sense field while the pin is steady never sets a pending flag.
- R12: Address 0 holds channel i's sense field in bits 2i+1:2i. Address 1 holds the enable bits. Both read back the value last written. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_CH | Asynchronous external interrupt pins |
| gie_i | input | 1 | Global interrupt enable from the CPU |
| ack_i | input | NUM_CH | One-cycle acknowledge per channel, pulsed when its service routine starts |
| reg_addr_i | input | ADDR_W | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| irq_req_o | output | NUM_CH | Interrupt request per channel |

## Verification
The bench drives each sense mode with pin changes in both directions. This separates falling-only, rising-only and any-change detection. It also samples the flag one edge before and exactly at the expected edge, which pins the synchroniser latency down to a single cycle. Holding the pin low in low level mode across acknowledges, with the channel enabled and disabled, separates a level-driven request from a latched flag. Collisions between a clear write and a new edge, and sense changes on a steady pin, show whether events are kept and whether spurious events are kept out.

// File: rtl/ext_irq_pkg.sv
// Package: shared sense-mode encoding and register addresses for the
// external interrupt sense controller.
package ext_irq_pkg;

    // Sense-control encoding; the value 00 is the reset (level) mode.
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    // Register map word addresses.
    localparam int REG_SENSE = 0;
    localparam int REG_EN    = 1;
    localparam int REG_PEND  = 2;

endpackage

// File: rtl/irq_pin_sync.sv
// Module: irq_pin_sync
// Multi-flop synchroniser for asynchronous pin inputs.
// Assumes: STAGES >= 2; each bit is treated independently (no bus coherency).
module irq_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the pin samples through the flop chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_edge_sense.sv
// Module: irq_edge_sense
// Per-channel event detector. It compares the synchronised level with the
// level one cycle earlier and reports the edge that the sense mode selects.
// It also reports the level-mode request condition.
// Assumes: lvl_i is already synchronous. The previous-sample register updates
// every cycle in every mode, so a mode change alone never creates an edge.
module irq_edge_sense
    import ext_irq_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   lvl_i,
    input  sense_e mode_i,
    output logic   hit_o,
    output logic   low_req_o
);
    logic prev_q;
    logic rise;
    logic fall;

    // Track the previous synchronised sample, regardless of mode.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= lvl_i;
    end

    assign rise = lvl_i & ~prev_q;
    assign fall = ~lvl_i & prev_q;

    // Select the edge that counts as an event for the current mode.
    always_comb begin
        unique case (mode_i)
            SENSE_ANY:  hit_o = rise | fall;
            SENSE_FALL: hit_o = fall;
            SENSE_RISE: hit_o = rise;
            default:    hit_o = 1'b0;
        endcase
    end

    assign low_req_o = (mode_i == SENSE_LOW) & ~lvl_i;
endmodule

// File: rtl/irq_pend_flag.sv
// Module: irq_pend_flag
// Pending flag of one channel. An edge event sets it; a write-one clear or an
// acknowledge clears it. When an event and a clear coincide, the event wins.
// In level mode the flag is held at zero.
// Assumes: hit_i, clr_i and ack_i are single-cycle synchronous strobes.
module irq_pend_flag
    import ext_irq_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  sense_e mode_i,
    input  logic   hit_i,
    input  logic   clr_i,
    input  logic   ack_i,
    output logic   flag_o
);
    logic flag_q;

    // Update the flag with priority: reset, level mode, event, clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                  flag_q <= 1'b0;
        else if (mode_i == SENSE_LOW) flag_q <= 1'b0;
        else if (hit_i)               flag_q <= 1'b1;
        else if (clr_i || ack_i)      flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/irq_ctrl_regs.sv
// Module: irq_ctrl_regs
// Register port: holds the sense fields and the enable mask, decodes the
// write-one-to-clear strobe for the pending flags, and muxes read data.
// Assumes: DATA_W >= 2*NUM_CH; reads are combinational, writes take effect
// at the clock edge where reg_we_i is high.
module irq_ctrl_regs
    import ext_irq_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic                   we_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic [NUM_CH-1:0]      pend_i,
    output logic [DATA_W-1:0]      rdata_o,
    output logic [NUM_CH-1:0][1:0] sense_o,
    output logic [NUM_CH-1:0]      en_o,
    output logic [NUM_CH-1:0]      w1c_o
);
    localparam int SENSE_W = 2 * NUM_CH;

    logic                   sel_sense;
    logic                   sel_en;
    logic                   sel_pend;
    logic [NUM_CH-1:0][1:0] sense_q;
    logic [NUM_CH-1:0]      en_q;
    logic                   unused_wbits;

    assign sel_sense = (addr_i == ADDR_W'(REG_SENSE));
    assign sel_en    = (addr_i == ADDR_W'(REG_EN));
    assign sel_pend  = (addr_i == ADDR_W'(REG_PEND));

    // Store the sense fields and the enable mask on register writes.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sense_q <= '0;
            en_q    <= '0;
        end else if (we_i) begin
            if (sel_sense) sense_q <= wdata_i[SENSE_W-1:0];
            if (sel_en)    en_q    <= wdata_i[NUM_CH-1:0];
        end
    end

    // Produce the write-one-to-clear strobe for the pending flags.
    assign w1c_o = (we_i && sel_pend) ? wdata_i[NUM_CH-1:0] : '0;

    // Select read data; unmapped addresses read zero.
    always_comb begin
        rdata_o = '0;
        if (sel_sense)     rdata_o[SENSE_W-1:0] = sense_q;
        else if (sel_en)   rdata_o[NUM_CH-1:0]  = en_q;
        else if (sel_pend) rdata_o[NUM_CH-1:0]  = pend_i;
    end

    assign sense_o      = sense_q;
    assign en_o         = en_q;
    assign unused_wbits = ^wdata_i;
endmodule

// File: rtl/ext_irq_sense.sv
// Module: ext_irq_sense (top)
// External interrupt sense controller: synchronises the pins, detects the
// event each channel's sense field selects, keeps the pending flags, and
// gates the requests with the per-channel and global enables.
// Assumes: ack_i pulses for one cycle when the CPU enters a service routine.
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] pin_i,
    input  logic              gie_i,
    input  logic [NUM_CH-1:0] ack_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic [NUM_CH-1:0] irq_req_o
);
    logic [NUM_CH-1:0]      sync_lvl;
    logic [NUM_CH-1:0]      edge_hit;
    logic [NUM_CH-1:0]      low_req;
    logic [NUM_CH-1:0]      pend_q;
    logic [NUM_CH-1:0]      w1c;
    logic [NUM_CH-1:0]      en_q;
    logic [NUM_CH-1:0][1:0] sense_q;

    irq_pin_sync #(
        .WIDTH  (NUM_CH),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pin_i),
        .sync_o  (sync_lvl)
    );

    irq_ctrl_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .addr_i  (reg_addr_i),
        .we_i    (reg_we_i),
        .wdata_i (reg_wdata_i),
        .pend_i  (pend_q),
        .rdata_o (reg_rdata_o),
        .sense_o (sense_q),
        .en_o    (en_q),
        .w1c_o   (w1c)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        irq_edge_sense edge_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .lvl_i     (sync_lvl[ch]),
            .mode_i    (sense_e'(sense_q[ch])),
            .hit_o     (edge_hit[ch]),
            .low_req_o (low_req[ch])
        );

        irq_pend_flag flag_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .mode_i (sense_e'(sense_q[ch])),
            .hit_i  (edge_hit[ch]),
            .clr_i  (w1c[ch]),
            .ack_i  (ack_i[ch]),
            .flag_o (pend_q[ch])
        );

        // Gate the channel's pending condition with both enables.
        assign irq_req_o[ch] = (pend_q[ch] | low_req[ch]) & en_q[ch] & gie_i;
    end
endmodule

// File: rtl/ext_irq_sense_chk.sv
// Module: ext_irq_sense_chk
// Property checker for ext_irq_sense, bound into every instance.
// Assumes: it observes top-level internal nets by name through the bind.
module ext_irq_sense_chk #(
    parameter int NUM_CH = 2
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   gie_i,
    input logic [NUM_CH-1:0]      ack_i,
    input logic [NUM_CH-1:0]      irq_req_o,
    input logic [NUM_CH-1:0][1:0] sense_q,
    input logic [NUM_CH-1:0]      en_q,
    input logic [NUM_CH-1:0]      pend_q,
    input logic [NUM_CH-1:0]      sync_lvl,
    input logic [NUM_CH-1:0]      edge_hit
);
    logic [NUM_CH-1:0] low_mask;
    logic [NUM_CH-1:0] ack_only_q;
    logic [NUM_CH-1:0] hit_q;

    // Mark the channels whose sense field selects level mode.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) low_mask[i] = (sense_q[i] == 2'b00);
    end

    // Remember last cycle's acknowledges without an event, and its armed events.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ack_only_q <= '0;
            hit_q      <= '0;
        end else begin
            ack_only_q <= ack_i & ~edge_hit;
            hit_q      <= edge_hit & ~low_mask;
        end
    end

    assert_req_needs_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_req_o & ~en_q) == '0);

    assert_req_needs_gie_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gie_i |-> (irq_req_o == '0));

    assert_low_flag_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q & low_mask) == '0);

    assert_low_level_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((low_mask & en_q & ~sync_lvl & {NUM_CH{gie_i}}) & ~irq_req_o) == '0);

    assert_ack_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q & ack_only_q) == '0);

    assert_event_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q & hit_q) == hit_q);
endmodule

bind ext_irq_sense ext_irq_sense_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gie_i     (gie_i),
    .ack_i     (ack_i),
    .irq_req_o (irq_req_o),
    .sense_q   (sense_q),
    .en_q      (en_q),
    .pend_q    (pend_q),
    .sync_lvl  (sync_lvl),
    .edge_hit  (edge_hit)
);

// File: tb/ext_irq_sense_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected values, a monitor compares
// them at the falling clock edge.
module ext_irq_sense_tb_top;
    localparam int NCH = 2;
    localparam int AW  = 2;
    localparam int DW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NCH-1:0] pins = '0;
    logic          gie = 1'b0;
    logic [NCH-1:0] ack = '0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NCH-1:0] irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    typedef struct {
        string         req;
        logic [AW-1:0] addr;
        logic [DW-1:0] exp_rd;
        bit            use_irq;
        logic [NCH-1:0] exp_irq;
    } item_t;

    item_t exp_q[$];

    always #2.5 clk = ~clk;

    ext_irq_sense #(.NUM_CH(NCH), .SYNC_STAGES(2), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pin_i       (pins),
        .gie_i       (gie),
        .ack_i       (ack),
        .reg_addr_i  (addr),
        .reg_we_i    (we),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_req_o   (irq)
    );

    // Monitor: pop queued expectations and compare at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                vectors++;
                if (rdata !== it.exp_rd) begin
                    miscompares++;
                    $display("FAIL %s: addr %0d read 0x%02h, expected 0x%02h",
                             it.req, it.addr, rdata, it.exp_rd);
                end
                if (it.use_irq) begin
                    vectors++;
                    if (irq !== it.exp_irq) begin
                        miscompares++;
                        $display("FAIL %s: irq 0b%b, expected 0b%b", it.req, irq, it.exp_irq);
                    end
                end
            end
        end
    end

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; wdata = d; we = 1'b1;
        tick(1);
        we = 1'b0;
    endtask

    task automatic chk_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string r);
        item_t it;
        addr = a;
        it = '{req: r, addr: a, exp_rd: e, use_irq: 1'b0, exp_irq: '0};
        exp_q.push_back(it);
        tick(1);
    endtask

    task automatic chk_both(input logic [AW-1:0] a, input logic [DW-1:0] e,
                            input logic [NCH-1:0] ei, input string r);
        item_t it;
        addr = a;
        it = '{req: r, addr: a, exp_rd: e, use_irq: 1'b1, exp_irq: ei};
        exp_q.push_back(it);
        tick(1);
    endtask

    task automatic pulse_ack(input logic [NCH-1:0] m);
        ack = m;
        tick(1);
        ack = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Driver: stimulus sequence.
    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1: reset state
        chk_both(2'd0, 8'h00, 2'b00, "R1");
        chk_rd(2'd1, 8'h00, "R1");
        chk_both(2'd2, 8'h00, 2'b00, "R1");

        pins = 2'b11;
        tick(4);
        // R12: register layout (ch0 falling, ch1 rising)
        wr(2'd1, 8'h03);
        wr(2'd0, 8'h0E);
        chk_rd(2'd0, 8'h0E, "R12");
        chk_rd(2'd1, 8'h03, "R12");
        chk_rd(2'd3, 8'h00, "R12");
        // R11: leaving level mode on a steady high pin
        chk_rd(2'd2, 8'h00, "R11");
        gie = 1'b1;

        // R2: falling edge on ch0, latency check
        pins[0] = 1'b0;
        tick(2);
        chk_both(2'd2, 8'h00, 2'b00, "R2");
        chk_both(2'd2, 8'h01, 2'b01, "R2");

        // R7: each enable gates the request
        gie = 1'b0;
        chk_both(2'd2, 8'h01, 2'b00, "R7");
        gie = 1'b1;
        wr(2'd1, 8'h02);
        chk_both(2'd2, 8'h01, 2'b00, "R7");
        wr(2'd1, 8'h03);
        chk_both(2'd2, 8'h01, 2'b01, "R7");

        // R5: write zero keeps the flag, write one clears it
        wr(2'd2, 8'h02);
        chk_rd(2'd2, 8'h01, "R5");
        wr(2'd2, 8'h01);
        chk_both(2'd2, 8'h00, 2'b00, "R5");

        // R3: rising mode ignores falling, latches rising
        pins[1] = 1'b0;
        tick(4);
        chk_rd(2'd2, 8'h00, "R3");
        pins[1] = 1'b1;
        tick(2);
        chk_rd(2'd2, 8'h00, "R3");
        chk_both(2'd2, 8'h02, 2'b10, "R3");

        // R6: acknowledge clears the flag
        pulse_ack(2'b10);
        chk_both(2'd2, 8'h00, 2'b00, "R6");

        // R4: any-change mode on both channels
        wr(2'd0, 8'h05);
        chk_rd(2'd2, 8'h00, "R11");
        pins[0] = 1'b1;
        tick(3);
        chk_rd(2'd2, 8'h01, "R4");
        wr(2'd2, 8'h01);
        pins[0] = 1'b0;
        tick(3);
        chk_rd(2'd2, 8'h01, "R4");
        wr(2'd2, 8'h01);
        chk_rd(2'd2, 8'h00, "R5");

        // R10: edge and clear in the same cycle keep the flag set
        pins[0] = 1'b1;
        tick(3);
        pins[0] = 1'b0;
        tick(2);
        wr(2'd2, 8'h01);
        chk_rd(2'd2, 8'h01, "R10");
        wr(2'd2, 8'h01);
        chk_rd(2'd2, 8'h00, "R10");

        // R8/R9: ch0 level mode with the pin low
        wr(2'd0, 8'h04);
        chk_both(2'd2, 8'h00, 2'b01, "R8");
        pulse_ack(2'b01);
        chk_both(2'd2, 8'h00, 2'b01, "R9");
        wr(2'd1, 8'h02);
        chk_both(2'd2, 8'h00, 2'b00, "R8");
        wr(2'd1, 8'h03);
        pins[0] = 1'b1;
        tick(1);
        chk_both(2'd2, 8'h00, 2'b01, "R9");
        chk_both(2'd2, 8'h00, 2'b00, "R9");
        pins[0] = 1'b0;
        tick(2);
        chk_both(2'd2, 8'h00, 2'b01, "R9");

        // R11: level mode to falling mode on a steady low pin
        wr(2'd0, 8'h06);
        tick(3);
        chk_both(2'd2, 8'h00, 2'b00, "R11");

        tick(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule